// File: doc/BRIEF.md
# Sequential Event Trigger Sequencer

This block turns a stream of external events into an ordered series of trigger pulses, with one trigger for each event. Each of the input signals contributes two event sources: its rising edge and its falling edge. Every source has its own enable bit. The enabled sources are merged into a single event strobe. Each strobe restarts a delay counter and steps a three-bit index. The index picks the one compare channel, out of eight, that may fire while the counter runs. That channel emits a single-cycle trigger when the counter reaches its compare value.

One source, picked by a select field, acts as the master reload and opens a new control cycle. When it occurs, the index returns to zero and the staged compare values move into the active list. Software or another unit stages new compare values at any time. The values only take effect at the next master reload, so a control cycle always runs on one consistent set of delays. A control cycle holds up to eight sequenced triggers. After the eighth event the index returns to zero.

Top module: `seqEventTrigger`

## Requirements
- R1: After reset, `trigOut` is all zeros, `evtIdx` is 0 and `mrsOut` is 0, and the active compare list holds zeros.
- R2: Source number 2*i is the rising edge of `sigIn[i]` and source 2*i+1 is its falling edge. An edge is seen at the first clock edge where `sigIn[i]` differs from its registered copy. If a source's `evtEn` bit is 0 and the source is not the master reload, its edge leaves `evtIdx` unchanged and produces no trigger.
- R3: Each enabled event that is not a master reload adds one to `evtIdx`. After the eighth event, the index goes from 7 back to 0.
- R4: The source numbered by `mrsSel` is the master reload, whether or not its enable bit is set. It sets `evtIdx` to 0, pulses `mrsOut` high for one cycle and copies `cmpNext` into the active compare list. Changes to `cmpNext` without a master reload have no effect on trigger timing.
- R5: An enabled event in the same cycle as a master reload is absorbed by it: `evtIdx` becomes 0, not 1.
- R6: Suppose an event or master reload is seen at clock edge E and leaves the index at value c. Channel c's bit of `trigOut` is then high for exactly the one cycle after edge E+1+D, where D is channel c's active compare value (channel c sits at `cmpNext[c*CNT_W +: CNT_W]`).
- R7: At most one bit of `trigOut` is high in any cycle.
- R8: Each counting window produces at most one trigger. Without a new event, the counter stops at its maximum value and the trigger does not repeat.
- R9: If both edges of one signal are enabled, a rising edge followed by a falling edge counts as two events.
- R10: Several enabled edges seen at the same clock edge count as one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sigIn | input | NUM_SIG | Event input signals |
| evtEn | input | 2*NUM_SIG | Enable per event source (even = rise, odd = fall) |
| mrsSel | input | $clog2(2*NUM_SIG) | Number of the source that acts as master reload |
| cmpNext | input | 8*CNT_W | Staged compare values, channel c in slice c |
| trigOut | output | 8 | One-hot, single-cycle trigger pulses |
| evtIdx | output | 3 | Current event index (armed channel) |
| mrsOut | output | 1 | One-cycle pulse after each master reload |

## Verification
The assertions assume that `sigIn` is synchronous to `clk`. They also assume that `evtEn` and `mrsSel` stay stable while edges are being detected, because the index checks compare the index with the strobes of the previous cycle. The stimulus changes `sigIn` only at falling clock edges, and it changes `evtEn`, `mrsSel` and `cmpNext` only while no edge is pending. Events are spaced widely enough that each expected trigger window finishes before the next reload, except where a scenario deliberately cuts a window short.

// File: rtl/seqTrigPkg.sv
package seqTrigPkg;
  localparam int SEQ_IDX_W = 3;
  localparam int SEQ_NUM_CHAN = 1 << SEQ_IDX_W;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 reload;  // restart delay counter
    logic                 commit;  // load staged compares into active list
    logic [SEQ_IDX_W-1:0] chan;    // channel armed for the running window
  } seqStrobe_t;
endpackage

// File: rtl/seqEdgeSplit.sv
module seqEdgeSplit #(
  parameter int NUM_SIG = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SIG-1:0]   sigIn,
  output logic [2*NUM_SIG-1:0] evt
);
  logic [NUM_SIG-1:0] sigQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sigQ <= '0;
    else       sigQ <= sigIn;
  end

  // Even source = rising edge, odd source = falling edge
  for (genvar i = 0; i < NUM_SIG; i++) begin : gPair
    assign evt[2*i]   =  sigIn[i] & ~sigQ[i];
    assign evt[2*i+1] = ~sigIn[i] &  sigQ[i];
  end
endmodule

// File: rtl/seqControl.sv
module seqControl
  import seqTrigPkg::*;
#(
  parameter int NUM_SIG = 16,
  localparam int NUM_EVT = 2 * NUM_SIG,
  localparam int SEL_W = $clog2(NUM_EVT)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_EVT-1:0]   evt,
  input  logic [NUM_EVT-1:0]   evtEn,
  input  logic [SEL_W-1:0]     mrsSel,
  output seqStrobe_t           strobe,
  output logic [SEQ_IDX_W-1:0] evtIdx,
  output logic                 mrsOut
);
  logic evtStrobe;
  logic mrsHit;
  logic [SEQ_IDX_W-1:0] idxQ;

  assign evtStrobe = |(evt & evtEn);
  assign mrsHit    = evt[mrsSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ   <= '0;
      mrsOut <= 1'b0;
    end else begin
      mrsOut <= mrsHit;
      if (mrsHit)         idxQ <= '0;
      else if (evtStrobe) idxQ <= idxQ + 1'b1;
    end
  end

  assign evtIdx        = idxQ;
  assign strobe.reload = evtStrobe | mrsHit;
  assign strobe.commit = mrsHit;
  assign strobe.chan   = idxQ;

  AST_MRS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    mrsHit |=> (evtIdx == '0)); // R4
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (evtStrobe && !mrsHit) |=> (evtIdx == SEQ_IDX_W'($past(evtIdx) + 1'b1))); // R3
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!evtStrobe && !mrsHit) |=> $stable(evtIdx)); // R2
  AST_MRS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    mrsHit |=> mrsOut); // R4
endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqTrigPkg::*;
#(
  parameter int CNT_W = 16,
  localparam int NUM_CHAN = SEQ_NUM_CHAN
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqStrobe_t                strobe,
  input  logic [NUM_CHAN*CNT_W-1:0] cmpNext,
  output logic [NUM_CHAN-1:0]       trigOut
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] activeCmp [NUM_CHAN];
  logic [CNT_W-1:0] cnt;
  logic             running;
  logic             fired;
  logic             match;

  // Double-buffered compare list: staged values land on master reload
  for (genvar g = 0; g < NUM_CHAN; g++) begin : gCmp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              activeCmp[g] <= '0;
      else if (strobe.commit) activeCmp[g] <= cmpNext[g*CNT_W +: CNT_W];
    end

    AST_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
      strobe.commit |=> (activeCmp[g] == $past(cmpNext[g*CNT_W +: CNT_W]))); // R4
  end

  assign match = running && !fired && (cnt == activeCmp[strobe.chan]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      running <= 1'b0;
      fired   <= 1'b0;
      trigOut <= '0;
    end else begin
      trigOut <= match ? (NUM_CHAN'(1) << strobe.chan) : '0;
      if (strobe.reload) begin
        cnt     <= '0;
        running <= 1'b1;
        fired   <= 1'b0;
      end else if (running) begin
        if (match)          fired <= 1'b1;
        if (cnt != CNT_MAX) cnt   <= cnt + 1'b1;
      end
    end
  end

  AST_TRIG_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(trigOut)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !running |=> (trigOut == '0)); // R8
  AST_SINGLE_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    (fired && !strobe.reload) |=> (trigOut == '0)); // R8
endmodule

// File: rtl/seqEventTrigger.sv
module seqEventTrigger
  import seqTrigPkg::*;
#(
  parameter int NUM_SIG = 16,
  parameter int CNT_W = 16,
  localparam int NUM_EVT = 2 * NUM_SIG,
  localparam int SEL_W = $clog2(NUM_EVT),
  localparam int NUM_CHAN = SEQ_NUM_CHAN
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SIG-1:0]        sigIn,
  input  logic [NUM_EVT-1:0]        evtEn,
  input  logic [SEL_W-1:0]          mrsSel,
  input  logic [NUM_CHAN*CNT_W-1:0] cmpNext,
  output logic [NUM_CHAN-1:0]       trigOut,
  output logic [SEQ_IDX_W-1:0]      evtIdx,
  output logic                      mrsOut
);
  logic [NUM_EVT-1:0] evt;
  seqStrobe_t         strobe;

  seqEdgeSplit #(.NUM_SIG(NUM_SIG)) uEdge (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .evt(evt)
  );

  seqControl #(.NUM_SIG(NUM_SIG)) uCtrl (
    .clk(clk), .rstN(rstN), .evt(evt), .evtEn(evtEn), .mrsSel(mrsSel),
    .strobe(strobe), .evtIdx(evtIdx), .mrsOut(mrsOut)
  );

  seqDatapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpNext(cmpNext),
    .trigOut(trigOut)
  );
endmodule

// File: tb/sim_seqEventTrigger.sv
`timescale 1ns/1ps
module sim_seqEventTrigger;
  localparam int NUM_SIG = 16;
  localparam int CNT_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [15:0]       sigIn = '0;
  logic [31:0]       evtEn = '0;
  logic [4:0]        mrsSel = '0;
  logic [8*CNT_W-1:0] cmpNext = '0;
  logic [7:0]        trigOut;
  logic [2:0]        evtIdx;
  logic              mrsOut;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int trigCnt = 0;
  int lastCyc = -1;
  logic [7:0] lastVec = '0;
  bit done = 0;

  seqEventTrigger #(.NUM_SIG(NUM_SIG), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .evtEn(evtEn), .mrsSel(mrsSel),
    .cmpNext(cmpNext), .trigOut(trigOut), .evtIdx(evtIdx), .mrsOut(mrsOut)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Trigger monitor, samples 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (trigOut != '0) begin
      trigCnt++;
      lastCyc = cyc;
      lastVec = trigOut;
      if ($countones(trigOut) > 1) begin
        errors++;
        $display("FAIL R7 trigOut not one-hot: act %b exp one bit", trigOut);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %0d exp %0d", tag, act, exp);
    end
  endtask

  task automatic setCmp(input int ch, input int v);
    cmpNext[ch*CNT_W +: CNT_W] = CNT_W'(v);
  endtask

  task automatic drive(input logic [15:0] v, output int k);
    @(negedge clk);
    k = cyc;
    sigIn = v;
    trigCnt = 0;
  endtask

  task automatic waitTo(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic expectIdx(input int k, input int exp, input string tag);
    waitTo(k + 1);
    check(evtIdx == 3'(exp), tag, evtIdx, exp);
  endtask

  task automatic expectTrig(input int k, input int ch, input int d, input string tag);
    waitTo(k + 2 + d + 4);
    check(trigCnt == 1, {tag, " trigger count"}, trigCnt, 1);
    check(lastVec == (8'd1 << ch), {tag, " trigger channel"}, lastVec, 1 << ch);
    check(lastCyc == k + 2 + d, {tag, " trigger cycle"}, lastCyc, k + 2 + d);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(trigOut == '0, "R1 trigOut", trigOut, 0);
    check(evtIdx == '0, "R1 evtIdx", evtIdx, 0);
    check(mrsOut == 1'b0, "R1 mrsOut", mrsOut, 0);
  endtask

  task automatic testMasterReload();
    int k;
    drive(16'h0002, k);               // sig1 rise = source 2 = MRS, enable clear
    waitTo(k + 1);
    check(mrsOut == 1'b1, "R4 mrsOut pulse", mrsOut, 1);
    check(evtIdx == 3'd0, "R4 index cleared", evtIdx, 0);
    expectTrig(k, 0, 3, "R6 ch0");
    drive(16'h0000, k);               // sig1 fall, source 3 disabled
    waitTo(k + 10);
    check(evtIdx == 3'd0, "R2 disabled edge index", evtIdx, 0);
    check(trigCnt == 0, "R2 disabled edge trigger", trigCnt, 0);
  endtask

  task automatic testWrap();
    int k;
    for (int n = 1; n <= 8; n++) begin
      drive(16'h0001, k);
      expectIdx(k, n % 8, "R3 index step");
      expectTrig(k, n % 8, 3 + (n % 8), "R3 sequenced");
      drive(16'h0000, k);
      waitTo(k + 3);
    end
  endtask

  task automatic testBothEdges();
    int k;
    evtEn[4] = 1'b1;
    evtEn[5] = 1'b1;
    drive(16'h0004, k);
    expectIdx(k, 1, "R9 rise");
    drive(16'h0000, k);
    expectIdx(k, 2, "R9 fall");
    expectTrig(k, 2, 5, "R9 ch2");
  endtask

  task automatic testSimultaneous();
    int k;
    drive(16'h0005, k);               // sig0 and sig2 rise together
    expectIdx(k, 3, "R10 merged");
    waitTo(k + 12);
    drive(16'h0000, k);               // sig2 fall enabled
    expectIdx(k, 4, "R10 next");
    waitTo(k + 12);
  endtask

  task automatic testCoincident();
    int k;
    drive(16'h0003, k);               // sig0 rise with MRS
    expectIdx(k, 0, "R5 coincident");
    expectTrig(k, 0, 3, "R5 ch0");
    drive(16'h0000, k);
    waitTo(k + 4);
  endtask

  task automatic testShadow();
    int k;
    setCmp(1, 20);
    drive(16'h0001, k);
    expectIdx(k, 1, "R4 no commit idx");
    expectTrig(k, 1, 4, "R4 old compare");
    drive(16'h0000, k);
    waitTo(k + 3);
    drive(16'h0002, k);               // MRS commits
    waitTo(k + 8);
    drive(16'h0000, k);
    waitTo(k + 3);
    drive(16'h0001, k);
    expectTrig(k, 1, 20, "R4 new compare");
    waitTo(k + 60);
    check(trigCnt == 1, "R8 no repeat", trigCnt, 1);
    drive(16'h0000, k);
    waitTo(k + 3);
  endtask

  task automatic testZeroDelay();
    int k;
    setCmp(0, 0);
    drive(16'h0002, k);
    expectTrig(k, 0, 0, "R6 zero delay");
  endtask

  initial begin
    evtEn = 32'h0000_0001;            // rising edge of sig0
    mrsSel = 5'd2;                    // rising edge of sig1
    for (int c = 0; c < 8; c++) setCmp(c, 3 + c);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMasterReload();
    testWrap();
    testBothEdges();
    testSimultaneous();
    testCoincident();
    testShadow();
    testZeroDelay();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act %0d exp %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule